// File: doc/BRIEF.md
# Fractional Oversampling Tick Generator

This block turns a kernel clock into the oversampling strobe that a serial receiver and transmitter use to time their bits. Software writes a 16-bit divisor word together with a mode bit choosing sixteen or eight samples per bit. The word is stored with a different layout in each mode. The block turns it into an effective divider D, which is the number of kernel clocks in one bit period in 16x mode and twice that number in 8x mode. It then produces a sample strobe at D/16 clocks per strobe, using a fractional accumulator so that a D that is not a multiple of 16 still gives exactly 16 strobes per D clocks. It also produces a bit strobe that marks the last sample of each bit.

Configuration values that the hardware cannot honour are reported on a status pin, and no strobes are produced while such a value is held. Every write restarts the phase, so the new rate starts from a known point. The write port and the status and strobe outputs are plain control pins, without a handshake. A write is taken on any clock edge where the write enable is high.

Top module: `baud_tick_gen`

## Requirements
- R1: In 16x mode (cfg_mode_8x = 0) the effective divider D equals the written word unchanged, bits 15:0.
- R2: In 8x mode (cfg_mode_8x = 1) D is rebuilt as {word[15:4], word[2:0], 1'b0}, so bit 3 of the word is not used and the lowest bit of D is always 0 (word 0x681 gives D = 0x682, and word 0x64 gives D = 0x68).
- R3: In 16x mode bit_tick pulses together with every 16th sample_tick after a write, giving one bit strobe per D clocks.
- R4: In 8x mode bit_tick pulses together with every 8th sample_tick after a write, giving one bit strobe per D/2 clocks.
- R5: cfg_illegal is high whenever D is below 16.
- R6: cfg_illegal is high whenever 8x mode is selected and bit 3 of the written word is 1.
- R7: While cfg_illegal is high, neither sample_tick nor bit_tick ever pulses.
- R8: A write clears the phase. On the clock edge that takes the write, both strobes go low. After k further edges, the number of sample_tick pulses since the write is exactly floor(16*k/D). This holds whatever the phase was before the write.
- R9: After reset the stored word is 0 in 16x mode, so cfg_illegal is high and no strobe pulses until a legal word is written.
- R10: With D = 16, sample_tick is high on every cycle after the write edge. This is the top rate: one bit per 16 clocks in 16x mode and one bit per 8 clocks in 8x mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for divisor word and mode |
| cfg_div | input | 16 | Divisor word in the layout of the selected mode |
| cfg_mode_8x | input | 1 | 0 selects 16 samples per bit, 1 selects 8 |
| cfg_illegal | output | 1 | Stored configuration cannot be honoured |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | Strobe on the last sample of each bit |

## Verification
The status pin changes as a result of the write edge itself, so the bench reads it at the first falling edge after that edge. At that same point both strobes must read 0. The strobes are registered one edge behind the accumulator. For this reason the bench counts sample pulses at each later falling edge and compares the running total after k edges with floor(16k/D). It compares the bit pulses with floor(16k/(D*OSR)), where OSR is 16 or 8. Because every write is timed from the write edge, the comparisons do not depend on the phase left over from the configuration before.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef enum logic {OSR_16X = 1'b0, OSR_8X = 1'b1} osr_mode_e;

  localparam int unsigned FRAC_BITS = 4;
  localparam int unsigned SAMPLES_MAX = 1 << FRAC_BITS;

  typedef struct packed {
    logic [15:0] word;
    osr_mode_e   mode;
  } baud_cfg_t;
endpackage

// File: rtl/baud_cfg_decode.sv
module baud_cfg_decode #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned MIN_DIV = 16
) (
  input  logic [DIV_W-1:0] word,
  input  logic             mode_8x,
  output logic [DIV_W-1:0] eff_div,
  output logic             illegal
);
  localparam int unsigned LOW_W = 3;

  logic [DIV_W-1:0] packed_8x;

  assign packed_8x = {word[DIV_W-1:LOW_W+1], word[LOW_W-1:0], 1'b0};

  always_comb begin
    if (mode_8x) begin
      eff_div = packed_8x;
      illegal = word[LOW_W] || (packed_8x < DIV_W'(MIN_DIV));
    end else begin
      eff_div = word;
      illegal = word < DIV_W'(MIN_DIV);
    end
  end
endmodule

// File: rtl/baud_frac_accum.sv
module baud_frac_accum #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned STEP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic [DIV_W-1:0] eff_div,
  output logic             tick
);
  localparam int unsigned ACC_W = DIV_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic             wrap;

  assign acc_nxt = acc_q + ACC_W'(STEP);
  assign wrap    = acc_nxt >= {1'b0, eff_div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (restart || hold) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (wrap) begin
      acc_q <= acc_nxt - {1'b0, eff_div};
      tick  <= 1'b1;
    end else begin
      acc_q <= acc_nxt;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_bit_group.sv
module baud_bit_group #(
  parameter int unsigned SAMPLES_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic mode_8x,
  input  logic sample,
  output logic bit_end
);
  localparam int unsigned CNT_W = $clog2(SAMPLES_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = mode_8x ? CNT_W'(SAMPLES_MAX / 2 - 1) : CNT_W'(SAMPLES_MAX - 1);
  assign bit_end  = sample && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (bit_end)  cnt_q <= '0;
    else if (sample)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_mode_8x,
  output logic             cfg_illegal,
  output logic             sample_tick,
  output logic             bit_tick
);
  logic [DIV_W-1:0] word_q;
  osr_mode_e        mode_q;
  logic [DIV_W-1:0] eff_div;
  logic             bad_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= OSR_16X;
    end else if (cfg_wr) begin
      word_q <= cfg_div;
      mode_q <= osr_mode_e'(cfg_mode_8x);
    end
  end

  baud_cfg_decode #(.DIV_W(DIV_W), .MIN_DIV(SAMPLES_MAX)) u_decode (
    .word    (word_q),
    .mode_8x (mode_q == OSR_8X),
    .eff_div (eff_div),
    .illegal (bad_cfg)
  );

  baud_frac_accum #(.DIV_W(DIV_W), .STEP(SAMPLES_MAX)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .hold    (bad_cfg),
    .eff_div (eff_div),
    .tick    (sample_tick)
  );

  baud_bit_group #(.SAMPLES_MAX(SAMPLES_MAX)) u_group (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .mode_8x (mode_q == OSR_8X),
    .sample  (sample_tick),
    .bit_end (bit_tick)
  );

  assign cfg_illegal = bad_cfg;
endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic cfg_mode_8x,
  input logic cfg_illegal,
  input logic sample_tick,
  input logic bit_tick
);
  logic       mode_c;
  logic [4:0] seen_c;
  logic [4:0] group_c;

  assign group_c = mode_c ? 5'd7 : 5'd15;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_c <= 1'b0;
      seen_c <= '0;
    end else if (cfg_wr) begin
      mode_c <= cfg_mode_8x;
      seen_c <= '0;
    end else if (sample_tick) begin
      seen_c <= bit_tick ? 5'd0 : seen_c + 5'd1;
    end
  end

  p_quiet_when_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (!sample_tick && !bit_tick));

  p_bit_inside_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!sample_tick && !bit_tick));

  p_group_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && seen_c == group_c) |-> bit_tick);

  p_group_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (seen_c == group_c));
endmodule

bind baud_tick_gen baud_tick_gen_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_mode_8x (cfg_mode_8x),
  .cfg_illegal (cfg_illegal),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        cfg_mode_8x = 1'b0;
  logic        cfg_illegal;
  logic        sample_tick;
  logic        bit_tick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk, .rst_n, .cfg_wr, .cfg_div, .cfg_mode_8x,
    .cfg_illegal, .sample_tick, .bit_tick
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint eff_of(input logic [15:0] w, input bit m8);
    if (m8) return longint'(w & 16'hFFF0) + longint'(w & 16'h0007) * 2;
    return longint'(w);
  endfunction

  task automatic run_cfg(input logic [15:0] w, input bit m8, input string tag);
    longint eff, osr, ncyc, s_cnt, b_cnt, exp_s, exp_b;
    longint bad_s_act, bad_s_exp, bad_b_act, bad_b_exp;
    bit ill, s_ok, b_ok;
    eff = eff_of(w, m8);
    osr = m8 ? 8 : 16;
    ill = (eff < 16) || (m8 && w[3]);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_div = w; cfg_mode_8x = m8;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(cfg_illegal == ill, {tag, " R5/R6 illegal flag"}, cfg_illegal, ill);
    check(!sample_tick && !bit_tick, {tag, " R8 strobes low after write edge"},
          sample_tick + bit_tick, 0);
    ncyc = ill ? 40 : ((eff * 3 > 3000) ? 3000 : eff * 3) + 20;
    s_cnt = 0; b_cnt = 0; s_ok = 1; b_ok = 1;
    bad_s_act = 0; bad_s_exp = 0; bad_b_act = 0; bad_b_exp = 0;
    for (longint k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      s_cnt += sample_tick;
      b_cnt += bit_tick;
      exp_s = ill ? 0 : (16 * k) / eff;
      exp_b = ill ? 0 : (16 * k) / (eff * osr);
      if (s_ok && s_cnt != exp_s) begin s_ok = 0; bad_s_act = s_cnt; bad_s_exp = exp_s; end
      if (b_ok && b_cnt != exp_b) begin b_ok = 0; bad_b_act = b_cnt; bad_b_exp = exp_b; end
    end
    if (ill) begin
      check(s_ok && b_ok, {tag, " R7 no strobes while illegal"}, bad_s_act + bad_b_act, 0);
    end else begin
      check(s_ok, {tag, m8 ? " R2 R8 sample count" : " R1 R8 sample count"}, bad_s_act, bad_s_exp);
      check(b_ok, {tag, m8 ? " R4 bit count" : " R3 bit count"}, bad_b_act, bad_b_exp);
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R9 illegal after reset", cfg_illegal, 1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      seen += sample_tick + bit_tick;
    end
    check(seen == 0, "R9 no strobes after reset", seen, 0);

    // R10: top rate, D = 16 in both modes
    run_cfg(16'h0010, 1'b0, "R10 16x D=16");
    run_cfg(16'h0010, 1'b1, "R10 8x D=16");

    // R1, R3: sweep of small 16x dividers
    for (int d = 16; d <= 80; d++) run_cfg(16'(d), 1'b0, "R1 sweep");
    // R2, R4: sweep of 8x words with bit 3 clear
    for (int w = 16; w < 96; w++) if (!w[3]) run_cfg(16'(w), 1'b1, "R2 sweep");

    // Worked values
    run_cfg(16'h0341, 1'b0, "R1 0x341");
    run_cfg(16'h0034, 1'b0, "R1 0x34");
    run_cfg(16'h0681, 1'b1, "R2 0x681");
    run_cfg(16'h0064, 1'b1, "R2 0x64");

    // Illegal values and their recovery
    run_cfg(16'h000F, 1'b0, "R5 16x D=15");
    run_cfg(16'h0000, 1'b0, "R5 16x D=0");
    run_cfg(16'h0007, 1'b1, "R5 8x D=14");
    run_cfg(16'h0018, 1'b1, "R6 8x bit3");
    run_cfg(16'h0348, 1'b1, "R6 8x bit3 large");
    run_cfg(16'h0018, 1'b0, "R6 16x bit3 legal");

    // R8: rewrite mid-period restarts phase
    run_cfg(16'h0025, 1'b0, "R8 first");
    run_cfg(16'h0025, 1'b0, "R8 same word again");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule